// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block sits between a set of interrupt sources and a processor core that has two interrupt classes: a normal class and a fast class. For each class it masks the pending sources, picks the enabled source with the highest programmable level and presents a request line to the core. Alongside the request it presents a 32-bit vector word that software jumps through. The word is the vector base with the winning source number placed above two zero bits, so every source gets its own service-routine slot.

Each class keeps an active level and a small nesting stack. When the core takes a request, the controller pushes the level it was serving and makes the winner's level the active one. After that, only a strictly higher level can raise a new request. An end-of-service strobe pops the stack and restores the level that was interrupted. The fast class always outranks the normal class. When vectored operation is switched off for a class, that class falls back to a plain OR of its enabled pending bits and its vector word reads zero.

Top module: `prio_vec_intc`

## Requirements
- R1: While reset is asserted and directly after it, both requests, both vector words and both overflow flags are 0, and both classes are idle (active level 0, stack empty).
- R2: With the class's bit of `vec_on` clear (bit 0 normal, bit 1 fast), the request equals the OR of pending AND mask, the vector word is 0, and an acknowledge leaves that class's nesting state unchanged.
- R3: In vectored mode, source i has level = `src_prio[3i+2:3i]` + 1 (1..8, higher is more urgent), and the winner is the enabled pending source with the highest level, the lowest source number winning a tie.
- R4: In vectored mode the vector word carries `vec_base` in bits 22..7 and the winner number in bits 6..2, with all other bits 0; it is all zero when no enabled source is pending.
- R5: In vectored mode a request is raised only when the winner's level is strictly greater than the class's active level (0 when idle); an equal or lower level waits.
- R6: An acknowledge while the class's request is high pushes the active level onto the stack, and from the next cycle the winner's level is the active level.
- R7: An end-of-service strobe pops the stack and restores the interrupted level; popping the last entry returns the class to idle, and a strobe with an empty stack changes nothing.
- R8: An acknowledge (with request high) and an end-of-service strobe in the same cycle with a non-empty stack replace the active level by the winner's level and leave the stack depth and contents unchanged.
- R9: An acknowledge when the stack already holds `NEST_DEPTH` entries is ignored and sets that class's overflow flag, which stays set until reset.
- R10: The normal request is held low whenever the fast request is high or the fast stack is not empty.
- R11: An acknowledge while the class's request is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | NUM_SRC | Normal-class pending bits, one per source |
| irq_mask | input | NUM_SRC | Normal-class enable mask |
| fiq_pend | input | NUM_SRC | Fast-class pending bits |
| fiq_mask | input | NUM_SRC | Fast-class enable mask |
| src_prio | input | NUM_SRC*PRIO_W | Per-source level field, source i at bits [PRIO_W*i +: PRIO_W] |
| vec_base | input | BASE_W | Vector base placed at bit 7 of both vector words |
| vec_on | input | 2 | Vectored mode enable: bit 0 normal, bit 1 fast |
| irq_ack | input | 1 | Core takes the normal request |
| irq_eos | input | 1 | End of normal service |
| fiq_ack | input | 1 | Core takes the fast request |
| fiq_eos | input | 1 | End of fast service |
| irq_req | output | 1 | Normal-class request |
| irq_vec | output | 32 | Normal-class vector word |
| fiq_req | output | 1 | Fast-class request |
| fiq_vec | output | 32 | Fast-class vector word |
| irq_ovf | output | 1 | Sticky normal-class nesting overflow |
| fiq_ovf | output | 1 | Sticky fast-class nesting overflow |

## Verification
An acknowledge and an end-of-service strobe can arrive in the same cycle on one class, so the stack might be pushed and popped at once. The bench provokes this with the fast stack full and a higher-level source waiting. That case also makes the push ignored and the overflow flag set. After the combined cycle the bench judges the outcome by the levels that reappear on the request line over three further pops: 2, then 1, then idle. Those levels show that the depth and contents survived while only the active level changed.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NUM_SRC    = 16,
  parameter int PRIO_W     = 3,
  parameter int NEST_DEPTH = 8,
  parameter int BASE_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_pend,
  input  logic [NUM_SRC-1:0]        irq_mask,
  input  logic [NUM_SRC-1:0]        fiq_pend,
  input  logic [NUM_SRC-1:0]        fiq_mask,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [BASE_W-1:0]         vec_base,
  input  logic [1:0]                vec_on,
  input  logic                      irq_ack,
  input  logic                      irq_eos,
  input  logic                      fiq_ack,
  input  logic                      fiq_eos,
  output logic                      irq_req,
  output logic [31:0]               irq_vec,
  output logic                      fiq_req,
  output logic [31:0]               fiq_vec,
  output logic                      irq_ovf,
  output logic                      fiq_ovf
);
  localparam int LVL_W = $clog2((1 << PRIO_W) + 1);
  localparam int DEP_W = $clog2(NEST_DEPTH + 1);
  localparam int SP_W  = $clog2(NEST_DEPTH);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] act [2];
  logic [1:0] ack, eos, raw_req, req_out, busy, ovf;
  logic [31:0] vec [2];

  assign act[0] = irq_pend & irq_mask;
  assign act[1] = fiq_pend & fiq_mask;
  assign ack = {fiq_ack, irq_ack};
  assign eos = {fiq_eos, irq_eos};

  assign req_out[1] = raw_req[1];
  assign req_out[0] = raw_req[0] & ~raw_req[1] & ~busy[1];

  assign irq_req = req_out[0];
  assign fiq_req = req_out[1];
  assign irq_vec = vec[0];
  assign fiq_vec = vec[1];
  assign irq_ovf = ovf[0];
  assign fiq_ovf = ovf[1];

  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [LVL_W-1:0] best;
    logic [IDX_W-1:0] win;
    logic [LVL_W-1:0] lvl_q;
    logic [DEP_W-1:0] dep_q;
    logic [DEP_W-1:0] dep_m1;
    logic [LVL_W-1:0] stk_q [NEST_DEPTH];
    logic             ovf_q;
    logic             take, pop;

    always_comb begin
      best = '0;
      win  = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (act[c][i] && (LVL_W'(src_prio[i*PRIO_W +: PRIO_W]) + LVL_W'(1)) >= best) begin
          best = LVL_W'(src_prio[i*PRIO_W +: PRIO_W]) + LVL_W'(1);
          win  = IDX_W'(i);
        end
      end
    end

    always_comb begin
      vec[c] = '0;
      if (vec_on[c] && |act[c]) begin
        vec[c][7 +: BASE_W] = vec_base;
        vec[c][2 +: 5]      = 5'(win);
      end
    end

    assign raw_req[c] = vec_on[c] ? (best > lvl_q) : |act[c];
    assign busy[c]    = |dep_q;
    assign ovf[c]     = ovf_q;
    assign dep_m1     = dep_q - DEP_W'(1);
    assign take       = vec_on[c] & ack[c] & req_out[c];
    assign pop        = eos[c] & |dep_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q <= '0;
        dep_q <= '0;
        ovf_q <= 1'b0;
        for (int k = 0; k < NEST_DEPTH; k++) stk_q[k] <= '0;
      end else if (take && pop) begin
        lvl_q <= best;
      end else if (take) begin
        if (dep_q == DEP_W'(NEST_DEPTH)) begin
          ovf_q <= 1'b1;
        end else begin
          stk_q[dep_q[SP_W-1:0]] <= lvl_q;
          dep_q <= dep_q + DEP_W'(1);
          lvl_q <= best;
        end
      end else if (pop) begin
        lvl_q <= stk_q[dep_m1[SP_W-1:0]];
        dep_q <= dep_m1;
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
  parameter int NUM_SRC    = 16,
  parameter int PRIO_W     = 3,
  parameter int NEST_DEPTH = 8,
  parameter int LVL_W      = 4,
  parameter int DEP_W      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         vec_on,
  input logic [NUM_SRC-1:0] irq_act,
  input logic [NUM_SRC-1:0] fiq_act,
  input logic               irq_req,
  input logic               fiq_req,
  input logic [31:0]        irq_vec,
  input logic [31:0]        fiq_vec,
  input logic               irq_ovf,
  input logic               fiq_ovf,
  input logic [LVL_W-1:0]   fiq_lvl,
  input logic [DEP_W-1:0]   irq_dep,
  input logic [DEP_W-1:0]   fiq_dep
);
  a_r10_fast_first: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (!fiq_req && fiq_dep == '0));

  a_r9_irq_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |=> irq_ovf);

  a_r9_fiq_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_ovf |=> fiq_ovf);

  a_r2_plain_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_on[0] |-> irq_vec == '0);

  a_r2_plain_req: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_on[1] |-> fiq_req == |fiq_act);

  a_r4_idle_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_act == '0) |-> fiq_vec == '0);

  a_r5_top_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_on[1] && fiq_lvl == LVL_W'(1 << PRIO_W)) |-> !fiq_req);

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_dep <= DEP_W'(NEST_DEPTH)) && (fiq_dep <= DEP_W'(NEST_DEPTH)));

  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_req && !fiq_req && !irq_ovf && !fiq_ovf));
endmodule

bind prio_vec_intc prio_vec_intc_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .NEST_DEPTH(NEST_DEPTH),
  .LVL_W(LVL_W), .DEP_W(DEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_on(vec_on),
  .irq_act(irq_pend & irq_mask), .fiq_act(fiq_pend & fiq_mask),
  .irq_req(irq_req), .fiq_req(fiq_req), .irq_vec(irq_vec), .fiq_vec(fiq_vec),
  .irq_ovf(irq_ovf), .fiq_ovf(fiq_ovf),
  .fiq_lvl(g_cls[1].lvl_q), .irq_dep(g_cls[0].dep_q), .fiq_dep(g_cls[1].dep_q)
);

// File: tb/prio_vec_intc_tb.sv
`timescale 1ns/1ps
module prio_vec_intc_tb;
  localparam int N = 8;
  localparam int PW = 3;
  localparam int DEPTH = 3;
  localparam logic [15:0] BASE = 16'hA5C3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_pend = '0, irq_mask = '0, fiq_pend = '0, fiq_mask = '0;
  logic [N*PW-1:0] src_prio = '0;
  logic [1:0] vec_on = '0;
  logic irq_ack = 0, irq_eos = 0, fiq_ack = 0, fiq_eos = 0;
  logic irq_req, fiq_req, irq_ovf, fiq_ovf;
  logic [31:0] irq_vec, fiq_vec;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    string tag;
    logic ir; logic [31:0] iv; logic fr; logic [31:0] fv; logic [1:0] ov;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  prio_vec_intc #(.NUM_SRC(N), .PRIO_W(PW), .NEST_DEPTH(DEPTH), .BASE_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_mask(irq_mask),
    .fiq_pend(fiq_pend), .fiq_mask(fiq_mask), .src_prio(src_prio),
    .vec_base(BASE), .vec_on(vec_on), .irq_ack(irq_ack), .irq_eos(irq_eos),
    .fiq_ack(fiq_ack), .fiq_eos(fiq_eos), .irq_req(irq_req), .irq_vec(irq_vec),
    .fiq_req(fiq_req), .fiq_vec(fiq_vec), .irq_ovf(irq_ovf), .fiq_ovf(fiq_ovf));

  function automatic logic [31:0] vw(int i);
    return {9'b0, BASE, 5'(i), 2'b00};
  endfunction

  task automatic ex(string tag, logic ir, logic [31:0] iv, logic fr, logic [31:0] fv, logic [1:0] ov);
    item_t it;
    it.tag = tag; it.ir = ir; it.iv = iv; it.fr = fr; it.fv = fv; it.ov = ov;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (irq_req !== it.ir || irq_vec !== it.iv || fiq_req !== it.fr ||
          fiq_vec !== it.fv || {fiq_ovf, irq_ovf} !== it.ov) begin
        fails++;
        $display("FAIL %s: got irq %b/%h fiq %b/%h ovf %b, expected irq %b/%h fiq %b/%h ovf %b",
                 it.tag, irq_req, irq_vec, fiq_req, fiq_vec, {fiq_ovf, irq_ovf},
                 it.ir, it.iv, it.fr, it.fv, it.ov);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // levels: src0=2 src1=4 src2=4 src3=7 src4=8 src5=1
    src_prio[0*PW +: PW] = 3'd1; src_prio[1*PW +: PW] = 3'd3; src_prio[2*PW +: PW] = 3'd3;
    src_prio[3*PW +: PW] = 3'd6; src_prio[4*PW +: PW] = 3'd7; src_prio[5*PW +: PW] = 3'd0;
    @(posedge clk); #1;
    ex("R1 in reset", 0, 0, 0, 0, 0);
    rst_n = 1;
    ex("R1 after reset", 0, 0, 0, 0, 0);

    // R2 plain mode
    irq_pend = 8'h06; irq_mask = 8'h04;
    ex("R2 plain OR", 1, 0, 0, 0, 0);
    irq_ack = 1; ex("R2 plain ack", 1, 0, 0, 0, 0); irq_ack = 0;
    irq_mask = 8'h00;
    ex("R2 masked", 0, 0, 0, 0, 0);

    // R3 tie, and R2 ack left no push
    irq_mask = 8'hFF; vec_on = 2'b01;
    ex("R3 tie lowest wins / R2 no push", 1, vw(1), 0, 0, 0);
    irq_pend = 8'h0E;
    ex("R3 highest level", 1, vw(3), 0, 0, 0);
    irq_ack = 1; ex("R6 ack cycle", 1, vw(3), 0, 0, 0); irq_ack = 0;
    ex("R6 R5 equal waits", 0, vw(3), 0, 0, 0);
    irq_ack = 1; ex("R11 ack with req low", 0, vw(3), 0, 0, 0); irq_ack = 0;
    irq_pend = 8'h1E;
    ex("R5 higher preempts", 1, vw(4), 0, 0, 0);
    irq_ack = 1; ex("R6 nested ack", 1, vw(4), 0, 0, 0); irq_ack = 0;
    ex("R6 top level", 0, vw(4), 0, 0, 0);

    irq_pend = 8'h0E; irq_eos = 1;
    ex("R7 eos cycle", 0, vw(3), 0, 0, 0); irq_eos = 0;
    ex("R7 restored level 7", 0, vw(3), 0, 0, 0);
    irq_pend = 8'h06;
    ex("R5 lower waits", 0, vw(1), 0, 0, 0);
    irq_eos = 1; ex("R7 second eos", 0, vw(1), 0, 0, 0); irq_eos = 0;
    ex("R7 R11 idle after two pops", 1, vw(1), 0, 0, 0);
    irq_eos = 1; ex("R7 eos empty", 1, vw(1), 0, 0, 0); irq_eos = 0;
    ex("R7 empty pop harmless", 1, vw(1), 0, 0, 0);

    // R10 fast over normal
    vec_on = 2'b11; fiq_mask = 8'hFF; fiq_pend = 8'h20;
    ex("R10 fast request wins", 0, vw(1), 1, vw(5), 0);
    fiq_ack = 1; ex("R10 fast ack", 0, vw(1), 1, vw(5), 0); fiq_ack = 0;
    ex("R10 fast busy blocks normal", 0, vw(1), 0, vw(5), 0);
    fiq_pend = 8'h00; fiq_eos = 1;
    ex("R4 idle vector zero", 0, vw(1), 0, 0, 0); fiq_eos = 0;
    ex("R10 normal released", 1, vw(1), 0, 0, 0);

    // R9 overflow at depth 3
    fiq_pend = 8'h20; fiq_ack = 1;
    ex("R9 push 1", 0, vw(1), 1, vw(5), 0); fiq_ack = 0;
    fiq_pend = 8'h21;
    ex("R5 level 2 over 1", 0, vw(1), 1, vw(0), 0);
    fiq_ack = 1; ex("R9 push 2", 0, vw(1), 1, vw(0), 0); fiq_ack = 0;
    fiq_pend = 8'h23;
    ex("R5 level 4 over 2", 0, vw(1), 1, vw(1), 0);
    fiq_ack = 1; ex("R9 push 3", 0, vw(1), 1, vw(1), 0); fiq_ack = 0;
    fiq_pend = 8'h33;
    ex("R5 level 8 over 4", 0, vw(1), 1, vw(4), 0);
    fiq_ack = 1; ex("R9 push when full", 0, vw(1), 1, vw(4), 0); fiq_ack = 0;
    ex("R9 overflow set, level kept", 0, vw(1), 1, vw(4), 2'b10);

    // R8 ack and eos together
    fiq_ack = 1; fiq_eos = 1;
    ex("R8 combined cycle", 0, vw(1), 1, vw(4), 2'b10);
    fiq_ack = 0; fiq_eos = 0;
    ex("R8 active replaced by 8", 0, vw(1), 0, vw(4), 2'b10);
    fiq_eos = 1; ex("R8 pop a", 0, vw(1), 0, vw(4), 2'b10); fiq_eos = 0;
    ex("R8 stack kept: level 2", 0, vw(1), 1, vw(4), 2'b10);
    fiq_pend = 8'h20;
    ex("R8 level 1 waits under 2", 0, vw(1), 0, vw(5), 2'b10);
    fiq_eos = 1; ex("R8 pop b", 0, vw(1), 0, vw(5), 2'b10); fiq_eos = 0;
    ex("R8 level 1 restored", 0, vw(1), 0, vw(5), 2'b10);
    fiq_eos = 1; ex("R8 pop c", 0, vw(1), 0, vw(5), 2'b10); fiq_eos = 0;
    ex("R8 idle after three pops", 0, vw(1), 1, vw(5), 2'b10);
    fiq_pend = 8'h00;
    ex("R9 overflow sticky", 1, vw(1), 0, 0, 2'b10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule